// File: doc/BRIEF.md
# Video Filter Command Interpreter

This block sits behind a two-wire serial slave front end and turns the bytes written to the device into configuration state for a three-channel video anti-aliasing filter. The first byte after a write address is a one-byte opcode. Most opcodes set or clear a single bit of an 8-bit control/status register. One opcode arms the loading of the 8-bit filter corner-frequency register from the byte that follows it. Two opcodes choose which register a later read returns. The register bits drive the analog side directly: power-down, filter bypass, a clamp level per channel, composite/component input, internal/external sync and sync polarity.

The front end reports framing as single-cycle pulses: `start_i` for a START or a repeated START, `stop_i` for a STOP, and `rd_addr_i` when a read address has been accepted. It delivers each completed write data byte as `wr_i` with `wr_data_i`. The byte to send for a read appears on `rd_data_o` one cycle after `rd_addr_i`.

Top module: `vfilt_cmd_ctrl`

## Requirements
- R1: After reset the control/status register is 03h and the frequency register is FFh. `pwrdn_o`, `bypass_o`, `composite_o`, `ext_sync_o` and `sync_neg_o` are 0, and `clamp_hi_o` is 3'b110. Bit 0 of `clamp_hi_o` is channel 1.
- R2: Opcode 00h sets power-down (status bit 4). Opcode 01h clears it. All other settings keep their values.
- R3: Opcodes 02h/03h, 04h/05h and 06h/07h set the clamp of channel 1, 2 and 3 low (even opcode) or high (odd opcode). The flags are status bits 2, 1 and 0.
- R4: Each of the following opcodes writes one status bit, and no other status bit changes:
  - 08h writes 0 to bit 7 (component) and 09h writes 1 (composite).
  - 0Ah writes 0 to bit 6 (internal sync) and 0Bh writes 1 (external sync).
  - 0Ch writes 0 to bit 5 (positive polarity) and 0Dh writes 1 (negative polarity).
  - 0Eh writes 0 to bit 3 (filters on) and 0Fh writes 1 (bypass).
- R5: Each configuration output equals its status bit. A status read returns the full register with this layout: bit 7 composite, bit 6 external sync, bit 5 negative polarity, bit 4 power-down, bit 3 bypass, bits 2..0 the clamp-high flags of channels 1..3.
- R6: Opcode 10h returns the control/status register to 03h and leaves the frequency register unchanged.
- R7: After opcode 12h, the next written byte of the same transfer is loaded into the frequency register. `freq_o` shows it in the cycle after that byte.
- R8: A START or STOP that comes between opcode 12h and its data byte leaves the frequency register unchanged. After a repeated START, the next byte is decoded as a new opcode.
- R9: Opcode 11h selects the status register and 13h selects the frequency register as the read source. `rd_data_o` holds the selected register one cycle after `rd_addr_i`. After that read the source returns to status.
- R10: A read with no prior read-request opcode returns the control/status register.
- R11: Opcodes 14h to FFh change neither register.
- R12: Once a command is complete (one byte, or 12h with its data byte), further bytes are ignored until the next START. Commands separated by repeated STARTs are each applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| wr_i | input | 1 | Completed write data byte (pulse) |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 1 | Read address accepted (pulse) |
| rd_data_o | output | 8 | Byte to transmit for the read |
| freq_o | output | 8 | Filter corner-frequency code |
| pwrdn_o | output | 1 | Power-down |
| bypass_o | output | 1 | Filter bypass |
| clamp_hi_o | output | 3 | Clamp-high per channel, bit 0 = channel 1 |
| composite_o | output | 1 | Composite input selected |
| ext_sync_o | output | 1 | External sync selected |
| sync_neg_o | output | 1 | Negative external sync polarity |

## Verification
Every result is registered once. Configuration outputs and `freq_o` change in the cycle after the `wr_i` byte that causes them, and `rd_data_o` is valid in the cycle after `rd_addr_i`. The bench drives each pulse for one cycle from a falling edge and samples at the next falling edge, exactly one rising edge later. All 256 opcodes are swept from two different starting states. Each result is compared against an arithmetic model of the status register, both at the output pins and through a status read.

// File: rtl/vfilt_cmd_ctrl.sv
module vfilt_cmd_ctrl #(
  parameter logic [7:0] STAT_RST = 8'h03,
  parameter logic [7:0] FREQ_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] freq_o,
  output logic       pwrdn_o,
  output logic       bypass_o,
  output logic [2:0] clamp_hi_o,
  output logic       composite_o,
  output logic       ext_sync_o,
  output logic       sync_neg_o
);

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_FREQ} phase_t;

  phase_t     phase;
  logic [7:0] status, freq, stat_next;
  logic       rd_sel;
  logic [1:0] cidx;

  wire frame_evt = start_i | stop_i | rd_addr_i;
  wire byte_ok   = wr_i & ~frame_evt;
  wire cmd_take  = byte_ok & (phase == PH_CMD);
  wire freq_take = byte_ok & (phase == PH_FREQ);

  assign cidx = 2'd3 - wr_data_i[2:1];

  always_comb begin
    stat_next = status;
    case (wr_data_i) inside
      8'h00: stat_next[4] = 1'b1;
      8'h01: stat_next[4] = 1'b0;
      [8'h02:8'h07]: stat_next[cidx] = wr_data_i[0];
      [8'h08:8'h0F]: begin
        case (wr_data_i[2:1])
          2'd0: stat_next[7] = wr_data_i[0];
          2'd1: stat_next[6] = wr_data_i[0];
          2'd2: stat_next[5] = wr_data_i[0];
          default: stat_next[3] = wr_data_i[0];
        endcase
      end
      8'h10: stat_next = STAT_RST;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      status    <= STAT_RST;
      freq      <= FREQ_RST;
      rd_sel    <= 1'b0;
      rd_data_o <= STAT_RST;
    end else begin
      if (start_i)
        phase <= PH_CMD;
      else if (stop_i || rd_addr_i)
        phase <= PH_IDLE;
      else if (wr_i) begin
        if (phase == PH_CMD && wr_data_i == 8'h12) phase <= PH_FREQ;
        else phase <= PH_IDLE;
      end

      if (cmd_take) begin
        status <= stat_next;
        if (wr_data_i == 8'h11) rd_sel <= 1'b0;
        if (wr_data_i == 8'h13) rd_sel <= 1'b1;
      end
      if (freq_take) freq <= wr_data_i;

      if (rd_addr_i) begin
        rd_data_o <= rd_sel ? freq : status;
        rd_sel    <= 1'b0;
      end
    end
  end

  assign freq_o      = freq;
  assign composite_o = status[7];
  assign ext_sync_o  = status[6];
  assign sync_neg_o  = status[5];
  assign pwrdn_o     = status[4];
  assign bypass_o    = status[3];
  assign clamp_hi_o  = {status[0], status[1], status[2]};

  // R6
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && wr_data_i == 8'h10) |=> (status == STAT_RST && $stable(freq)));

  // R7
  freq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_take |=> (freq_o == $past(wr_data_i)));

  // R8
  freq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FREQ && (start_i || stop_i)) |=> $stable(freq_o));

  // R11
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && wr_data_i > 8'h13) |=> ($stable(status) && $stable(freq)));

  // R12
  ignore_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && phase == PH_IDLE && !start_i) |=> ($stable(status) && $stable(freq)));

  // R9
  rd_ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i |=> !rd_sel);

endmodule

// File: tb/tb_vfilt_cmd_ctrl.sv
module tb_vfilt_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, wr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o, freq_o;
  logic pwrdn_o, bypass_o, composite_o, ext_sync_o, sync_neg_o;
  logic [2:0] clamp_hi_o;
  int checks = 0, fails = 0;
  logic [7:0] exp_stat, exp_freq, got;

  always #5 clk = ~clk;

  vfilt_cmd_ctrl dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic p_start; @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask
  task automatic p_stop;  @(negedge clk) stop_i = 1;  @(negedge clk) stop_i = 0;  endtask
  task automatic p_rd;    @(negedge clk) rd_addr_i = 1; @(negedge clk) rd_addr_i = 0; endtask
  task automatic p_wr(input logic [7:0] b);
    @(negedge clk) begin wr_i = 1; wr_data_i = b; end
    @(negedge clk) wr_i = 0;
  endtask
  task automatic cmd(input logic [7:0] op); p_start; p_wr(op); p_stop; endtask
  task automatic rd_reg(input logic [7:0] sel, output logic [7:0] v);
    p_start; p_wr(sel); p_start; p_rd; v = rd_data_o; p_stop;
  endtask

  function automatic logic [7:0] model(input logic [7:0] s, input logic [7:0] op);
    logic [7:0] n = s;
    if (op == 8'h00) n[4] = 1;
    else if (op == 8'h01) n[4] = 0;
    else if (op >= 8'h02 && op <= 8'h07) n[2 - ((op - 2) / 2)] = op[0];
    else if (op == 8'h08 || op == 8'h09) n[7] = op[0];
    else if (op == 8'h0A || op == 8'h0B) n[6] = op[0];
    else if (op == 8'h0C || op == 8'h0D) n[5] = op[0];
    else if (op == 8'h0E || op == 8'h0F) n[3] = op[0];
    else if (op == 8'h10) n = 8'h03;
    return n;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op <= 8'h01) return "R2";
    if (op <= 8'h07) return "R3";
    if (op <= 8'h0F) return "R4";
    if (op == 8'h10) return "R6";
    if (op <= 8'h13) return "R12";
    return "R11";
  endfunction

  function automatic logic [7:0] pins();
    return {composite_o, ext_sync_o, sync_neg_o, pwrdn_o, bypass_o,
            clamp_hi_o[0], clamp_hi_o[1], clamp_hi_o[2]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status pins", pins(), 8'h03);
    chk("R1 freq", freq_o, 8'hFF);
    chk("R1 clamp", {5'd0, clamp_hi_o}, 8'h06);
    // R10 read without request
    p_start; p_rd; chk("R10 read no request", rd_data_o, 8'h03); p_stop;
    exp_stat = 8'h03; exp_freq = 8'hFF;

    // R2 R3 R4 R5 R6 R11 sweep from two bases
    for (int base = 0; base < 2; base++) begin
      for (int op = 0; op < 256; op++) begin
        cmd(8'h10);
        exp_stat = 8'h03;
        if (base == 1) begin
          cmd(8'h00); cmd(8'h09); cmd(8'h0B); cmd(8'h0D);
          cmd(8'h0F); cmd(8'h03); cmd(8'h04); cmd(8'h06);
          exp_stat = 8'hFC;
        end
        cmd(8'(op));
        exp_stat = model(exp_stat, 8'(op));
        chk({tag_of(8'(op)), " pins"}, pins(), exp_stat);
        chk({tag_of(8'(op)), " freq kept"}, freq_o, exp_freq);
        rd_reg(8'h11, got);
        chk("R5 status read", got, exp_stat);
      end
    end

    // R7 frequency loads
    foreach (exp_freq_vals[i]) ;
    for (int i = 0; i < 5; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h37 + 8'h01);
      p_start; p_wr(8'h12); p_wr(v); p_stop;
      exp_freq = v;
      chk("R7 freq_o", freq_o, v);
      rd_reg(8'h13, got);
      chk("R7 freq read", got, v);
      chk("R7 status kept", pins(), exp_stat);
    end

    // R6 soft reset spares frequency
    cmd(8'h10); exp_stat = 8'h03;
    chk("R6 status", pins(), 8'h03);
    chk("R6 freq", freq_o, exp_freq);

    // R8 aborts
    p_start; p_wr(8'h12); p_stop;
    p_start; p_wr(8'h77); p_stop;
    chk("R8 stop abort", freq_o, exp_freq);
    p_start; p_wr(8'h12); p_start; p_wr(8'h0F); p_stop;
    exp_stat = 8'h0B;
    chk("R8 sr abort freq", freq_o, exp_freq);
    chk("R8 sr new opcode", pins(), exp_stat);

    // R12 extra bytes ignored, Sr-chained commands applied
    p_start; p_wr(8'h00); p_wr(8'h0E); p_stop;
    exp_stat = 8'h1B;
    chk("R12 extra byte", pins(), exp_stat);
    p_start; p_wr(8'h09); p_start; p_wr(8'h0B); p_stop;
    exp_stat = 8'hDB;
    chk("R12 sr chain", pins(), exp_stat);
    p_start; p_wr(8'h12); p_wr(8'h33); p_wr(8'h44); p_stop;
    exp_freq = 8'h33;
    chk("R12 after freq byte", freq_o, 8'h33);

    // R9 pointer and return to status
    p_start; p_wr(8'h13); p_start; p_rd;
    chk("R9 freq read", rd_data_o, 8'h33); p_stop;
    p_start; p_rd;
    chk("R9 pointer back", rd_data_o, exp_stat); p_stop;
    rd_reg(8'h11, got);
    chk("R9 status read", got, exp_stat);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [7:0] exp_freq_vals [1];
endmodule